// File: doc/BRIEF.md
# 8-bit PWM Timer with Compare Match

An 8-bit up-counter with a loadable count, an 8-bit compare value and two event flags. It advances on a one-cycle enable `tick` that comes from a prescaler outside the block. Three operating modes are available. In plain counting the output pin stays low. In wrap PWM the counter runs 00..FF and rolls over. In phase-correct PWM the counter climbs to FF, turns, and descends to 00.

A two-bit register port reaches four registers. Writing the count reloads the counter. It also masks compare detection for the first tick that follows, so initialising a timer never raises a spurious compare event. The compare flag is registered twice, so it reaches software one clock after the match is detected. Both flags are cleared by writing 1 to their bit.

Two state machines carry the behaviour. The direction machine has states DIR_UP and DIR_DOWN. Its transitions are TURN_TOP (up at FE or FF, go down), TURN_BOTTOM (down at 01 or 00, go up) and FORCE_UP (any non-phase-correct mode). The waveform machine has states WAVE_LO and WAVE_HI. Its transitions are WRAP_SET (tick at FF in wrap mode), MATCH_CLR (unmasked match while rising or in wrap mode), MATCH_SET (unmasked match while descending) and PARK (plain counting mode).

Top module: `tmr8_pwm`

## Requirements
- R1: After reset, the count, compare, control and flag registers read 0, and `pwm_out`, `cmp_irq` and `ovf_irq` are low.
- R2: Register map on `reg_addr`: 0 = count, 1 = compare value, 2 = control (bit0 PWM enable, bit1 wrap select where 1 = wrap and 0 = phase-correct, bit2 output invert), 3 = flags (bit0 compare, bit1 overflow). `reg_rdata` reflects the addressed register in the same cycle.
- R3: The count changes only on a cycle with `tick` high or with a count write. A count write wins over a simultaneous tick, is visible after that clock edge, and counting resumes on the next tick.
- R4: With PWM disabled, or with wrap PWM, each tick adds one to the count, and FF rolls to 00.
- R5: In phase-correct PWM the count runs 00,01..FE,FF,FE..01,00 and repeats, for a period of 510 ticks. A count write keeps the current direction.
- R6: A tick taken while the count equals the compare value sets the compare flag. The flag is still low after that clock edge and reads high after the next one.
- R7: The first tick after a count write produces no compare event. The compare flag and the PWM output do not change on that tick.
- R8: The overflow flag is set at the edge of a tick that takes the count from FF to 00 (plain and wrap modes) or from 01 to 00 while descending (phase-correct mode).
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it. A flag event in the same cycle as its clear leaves the flag set.
- R10: Wrap PWM: the output goes high at the tick that rolls FF to 00, and goes low at an unmasked tick with count equal to the compare value, unless that value is FF. The output is high exactly while count <= compare, which is compare+1 of every 256 ticks.
- R11: Phase-correct PWM: an unmasked match clears the output while rising and sets it while descending. The output is high for 2*compare of every 510 ticks (0 gives constant low, FF gives constant high).
- R12: Control bit2 inverts the PWM output in both PWM modes. With PWM disabled, `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable from the prescaler |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pwm_out | output | 1 | PWM output pin |
| cmp_irq | output | 1 | Compare-match flag |
| ovf_irq | output | 1 | Overflow flag |

## Verification
Each result has a fixed latency. Count writes, tick steps, the overflow flag and the PWM output all land one clock edge after the cycle that causes them. The compare flag lands one edge later than that. Read data follows the address in the same cycle. The bench drives and samples only on falling edges. It checks the compare flag at the first falling edge after the matching tick, where the flag must still be low, and again at the second falling edge, where it must be high. PWM duty is counted over whole periods, after two settling periods, so that the masked first tick has no effect on the result.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_WRAP   = 2'd1,
        MODE_UPDN   = 2'd2
    } mode_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    typedef enum logic {
        WAVE_LO = 1'b0,
        WAVE_HI = 1'b1
    } wave_t;

    localparam logic [1:0] A_COUNT = 2'd0;
    localparam logic [1:0] A_CMP   = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_FLAG  = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_WRAP = 1;
    localparam int CTL_INV  = 2;
    localparam int CTL_W    = 3;

    localparam int FLG_CMP = 0;
    localparam int FLG_OVF = 1;

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  mode_t        mode,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output dir_t         dir,
    output logic         ovf_evt,
    output logic         blk
);
    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] TOP_M1 = TOP - 1'b1;
    localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

    dir_t         dir_q, dir_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         blk_q, blk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
            blk_q <= blk_d;
        end
    end

    // next state and count
    always_comb begin
        dir_d   = dir_q;
        cnt_d   = cnt_q;
        blk_d   = blk_q;
        ovf_evt = 1'b0;
        if (mode != MODE_UPDN) begin
            dir_d = DIR_UP;                         // FORCE_UP
        end
        if (ld) begin
            cnt_d = ld_val;
            blk_d = 1'b1;
        end else if (tick) begin
            blk_d = 1'b0;
            if (mode == MODE_UPDN) begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (cnt_q == TOP_M1) begin      // TURN_TOP
                            cnt_d = TOP;
                            dir_d = DIR_DOWN;
                        end else if (cnt_q == TOP) begin
                            cnt_d = TOP_M1;
                            dir_d = DIR_DOWN;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == ONE) begin         // TURN_BOTTOM
                            cnt_d   = '0;
                            dir_d   = DIR_UP;
                            ovf_evt = 1'b1;
                        end else if (cnt_q == '0) begin
                            cnt_d = ONE;
                            dir_d = DIR_UP;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                    default: dir_d = DIR_UP;
                endcase
            end else begin
                cnt_d   = cnt_q + 1'b1;
                ovf_evt = (cnt_q == TOP);
            end
        end
    end

    // outputs
    always_comb begin
        cnt = cnt_q;
        dir = dir_q;
        blk = blk_q;
    end

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         blk,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    output logic         hit,
    output logic         hit_q
);
    always_comb begin
        hit = tick && !blk && (cnt == ocr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_t        mode,
    input  logic         inv,
    input  logic         tick,
    input  logic         hit,
    input  dir_t         dir,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    output logic         pwm
);
    localparam logic [W-1:0] TOP = '1;

    wave_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WAVE_LO;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_NORMAL: st_d = WAVE_LO;                        // PARK
            MODE_WRAP: begin
                if (hit && ocr != TOP)   st_d = WAVE_LO;        // MATCH_CLR
                else if (tick && cnt == TOP) st_d = WAVE_HI;    // WRAP_SET
            end
            MODE_UPDN: begin
                if (hit) st_d = (dir == DIR_UP) ? WAVE_LO       // MATCH_CLR
                                                : WAVE_HI;      // MATCH_SET
            end
            default: st_d = WAVE_LO;
        endcase
    end

    // output
    always_comb begin
        pwm = (mode != MODE_NORMAL) && ((st_q == WAVE_HI) ^ inv);
    end

endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         pwm_out,
    output logic         cmp_irq,
    output logic         ovf_irq
);
    logic [W-1:0]      ocr_q;
    logic [CTL_W-1:0]  ctrl_q;
    logic              cmp_flag_q, ovf_flag_q;
    logic              ld_w, flg_wr;
    mode_t             mode_w;
    logic [W-1:0]      cnt_w;
    dir_t              dir_w;
    logic              ovf_w, blk_w, hit_w, hit_q_w;

    always_comb begin
        ld_w   = reg_wr && (reg_addr == A_COUNT);
        flg_wr = reg_wr && (reg_addr == A_FLAG);
        if (!ctrl_q[CTL_EN])        mode_w = MODE_NORMAL;
        else if (ctrl_q[CTL_WRAP])  mode_w = MODE_WRAP;
        else                        mode_w = MODE_UPDN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocr_q      <= '0;
            ctrl_q     <= '0;
            cmp_flag_q <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CMP)  ocr_q  <= reg_wdata;
            if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTL_W-1:0];
            if (hit_q_w)                                   cmp_flag_q <= 1'b1;
            else if (flg_wr && reg_wdata[FLG_CMP])         cmp_flag_q <= 1'b0;
            if (ovf_w)                                     ovf_flag_q <= 1'b1;
            else if (flg_wr && reg_wdata[FLG_OVF])         ovf_flag_q <= 1'b0;
        end
    end

    tmr8_count #(.W(W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_w),
        .ld(ld_w), .ld_val(reg_wdata), .cnt(cnt_w), .dir(dir_w),
        .ovf_evt(ovf_w), .blk(blk_w)
    );

    tmr8_cmp #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .blk(blk_w),
        .cnt(cnt_w), .ocr(ocr_q), .hit(hit_w), .hit_q(hit_q_w)
    );

    tmr8_wave #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .inv(ctrl_q[CTL_INV]),
        .tick(tick), .hit(hit_w), .dir(dir_w), .cnt(cnt_w), .ocr(ocr_q),
        .pwm(pwm_out)
    );

    always_comb begin
        unique case (reg_addr)
            A_COUNT: reg_rdata = cnt_w;
            A_CMP:   reg_rdata = ocr_q;
            A_CTRL:  reg_rdata = {{(W-CTL_W){1'b0}}, ctrl_q};
            A_FLAG:  reg_rdata = {{(W-2){1'b0}}, ovf_flag_q, cmp_flag_q};
            default: reg_rdata = '0;
        endcase
        cmp_irq = cmp_flag_q;
        ovf_irq = ovf_flag_q;
    end

endmodule

// File: rtl/tmr8_pwm_chk.sv
module tmr8_pwm_chk
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         ld,
    input logic [W-1:0] ld_val,
    input mode_t        mode,
    input logic [W-1:0] cnt,
    input dir_t         dir,
    input logic [W-1:0] ocr,
    input logic         blk,
    input logic         hit_q,
    input logic         cmp_flag,
    input logic         ovf_flag
);
    localparam logic [W-1:0] TOP = '1;

    // R3
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !ld |=> $stable(cnt));

    // R3
    load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld && mode != MODE_UPDN |=> cnt == W'($past(cnt) + 1'b1));

    // R5
    turn_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld && mode == MODE_UPDN && dir == DIR_UP && cnt == TOP - 1'b1
        |=> cnt == TOP && dir == DIR_DOWN);

    // R6
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !blk && cnt == ocr |=> ##1 cmp_flag);

    // R7
    mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && blk |=> !hit_q);

    // R8
    wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld && mode != MODE_UPDN && cnt == TOP |=> ovf_flag);

endmodule

bind tmr8_pwm tmr8_pwm_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld_w), .ld_val(reg_wdata),
    .mode(mode_w), .cnt(cnt_w), .dir(dir_w), .ocr(ocr_q), .blk(blk_w),
    .hit_q(hit_q_w), .cmp_flag(cmp_flag_q), .ovf_flag(ovf_flag_q)
);

// File: tb/tmr8_pwm_test.sv
`timescale 1ns/1ps
module tmr8_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pwm_out, cmp_irq, ovf_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr8_pwm #(.W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    // {control, compare, period in ticks, expected high ticks}
    localparam logic [39:0] VEC [9] = '{
        {8'h03, 8'h00, 12'd256, 12'd1},
        {8'h03, 8'h40, 12'd256, 12'd65},
        {8'h03, 8'hFF, 12'd256, 12'd256},
        {8'h07, 8'h40, 12'd256, 12'd191},
        {8'h01, 8'h00, 12'd510, 12'd0},
        {8'h01, 8'h80, 12'd510, 12'd256},
        {8'h01, 8'hFF, 12'd510, 12'd510},
        {8'h05, 8'h10, 12'd510, 12'd478},
        {8'h00, 8'h40, 12'd256, 12'd0}
    };

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic tick_n(int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        logic [7:0] ctl, ocr;
        logic [11:0] per, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register after reset", v, 0);
        end
        check("R1 pwm_out after reset", int'(pwm_out), 0);
        check("R1 cmp_irq after reset", int'(cmp_irq), 0);
        check("R1 ovf_irq after reset", int'(ovf_irq), 0);

        // R2 readback
        wr(2'd1, 8'hA5); rd(2'd1, v); check("R2 compare readback", v, 8'hA5);
        wr(2'd2, 8'hFF); rd(2'd2, v); check("R2 control readback", v, 7);
        wr(2'd2, 8'h00);

        // PWM table: R10 R11 R12
        for (int i = 0; i < 9; i++) begin
            int h, mism;
            string tag;
            {ctl, ocr, per, hi} = VEC[i];
            tick = 1'b0;
            wr(2'd2, ctl); wr(2'd1, ocr); wr(2'd0, 8'h00); wr(2'd3, 8'h03);
            reg_addr = 2'd0;
            tick = 1'b1;
            repeat (2 * int'(per)) @(negedge clk);
            h = 0; mism = 0;
            for (int k = 0; k < int'(per); k++) begin
                @(negedge clk);
                #1;
                if (pwm_out) h++;
                if (ctl[1:0] == 2'b11) begin
                    if (pwm_out !== ((reg_rdata <= ocr) ^ ctl[2])) mism++;
                end
            end
            tick = 1'b0;
            if (!ctl[0] || ctl[2]) tag = "R12 duty";
            else if (ctl[1])       tag = "R10 duty";
            else                   tag = "R11 duty";
            check(tag, h, int'(hi));
            if (ctl[1:0] == 2'b11) check("R10 phase vs count", mism, 0);
        end

        // R3 hold, load priority, resume
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h05);
        repeat (3) @(negedge clk);
        rd(2'd0, v); check("R3 hold without tick", v, 5);
        tick_n(1);
        rd(2'd0, v); check("R3 one tick", v, 6);
        @(negedge clk);
        tick = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h30; reg_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        rd(2'd0, v); check("R3 write beats tick", v, 8'h30);
        tick_n(1);
        rd(2'd0, v); check("R3 resume after write", v, 8'h31);

        // R4 R8 rollover
        wr(2'd0, 8'hFE); wr(2'd3, 8'h03);
        tick_n(1);
        check("R8 no overflow at FF", int'(ovf_irq), 0);
        tick_n(1);
        rd(2'd0, v); check("R4 roll to 00", v, 0);
        check("R8 overflow on roll", int'(ovf_irq), 1);
        rd(2'd3, v); check("R2 overflow flag bit1", v, 2);

        // R9 clear rules
        wr(2'd3, 8'h01);
        check("R9 write 0 keeps overflow", int'(ovf_irq), 1);
        wr(2'd3, 8'h02);
        check("R9 write 1 clears overflow", int'(ovf_irq), 0);
        wr(2'd0, 8'hFF);
        @(negedge clk);
        tick = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        check("R9 set beats clear", int'(ovf_irq), 1);

        // R6 compare flag latency
        wr(2'd1, 8'd10); wr(2'd0, 8'd8); wr(2'd3, 8'h03);
        tick_n(2);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R6 flag not yet set", int'(cmp_irq), 0);
        @(negedge clk);
        check("R6 flag set one clock later", int'(cmp_irq), 1);

        // R7 masked compare after write
        wr(2'd3, 8'h03); wr(2'd0, 8'd10);
        tick_n(1);
        repeat (3) @(negedge clk);
        check("R7 no flag after write", int'(cmp_irq), 0);
        rd(2'd0, v); check("R7 count still moved", v, 11);
        wr(2'd2, 8'h03); wr(2'd0, 8'hFF);
        tick_n(1);
        check("R10 high after roll", int'(pwm_out), 1);
        tick_n(10);
        wr(2'd0, 8'd10);
        tick_n(1);
        check("R7 output kept on masked match", int'(pwm_out), 1);
        tick_n(255);
        tick_n(1);
        check("R10 low after unmasked match", int'(pwm_out), 0);

        // R5 R8 phase-correct turns
        wr(2'd2, 8'h01); wr(2'd0, 8'hFD); wr(2'd3, 8'h03);
        tick_n(1); rd(2'd0, v); check("R5 rise to FE", v, 8'hFE);
        tick_n(1); rd(2'd0, v); check("R5 reach FF", v, 8'hFF);
        tick_n(1); rd(2'd0, v); check("R5 turn to FE", v, 8'hFE);
        wr(2'd0, 8'd2);
        tick_n(1); rd(2'd0, v); check("R5 write keeps down", v, 1);
        check("R8 no overflow at 01", int'(ovf_irq), 0);
        tick_n(1); rd(2'd0, v); check("R5 reach 00", v, 0);
        check("R8 overflow at bottom", int'(ovf_irq), 1);
        tick_n(1); rd(2'd0, v); check("R5 turn to 01", v, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule